// File: doc/BRIEF.md
# Multicart PRG/CHR Address Composer

This block sits between a bank-switching core of the MMC3 kind and the ROM chips of a multi-game cartridge. It merges the core's PRG and CHR bank outputs with the raw CPU and PPU address lines and with fields from outer bank registers. The result is the full PRG-ROM address (A21..A13) and CHR-ROM address (A19..A10). The block is purely combinational. Register storage and the core itself live elsewhere.

Two fixed-bank overrides can replace the core's normal banking. In the 16/32 KiB fixed PRG modes, the block feeds the core CPU A13/A14 held low, so that a single core bank register covers the whole $8000-$FFFF window. It then substitutes raw CPU address bits on the low PRG lines. In the 8 KiB fixed CHR mode, a 4-bit inner register replaces the core's CHR bank bits. Outer fields can either narrow the inner PRG and CHR banks to 128 KiB or leave them at 256 KiB. A select bit lets CPU reads of the ROM window return two configuration pad bits in place of ROM data.

Top module: `mc_addr_composer`

## Requirements
- R1: With prg_mode = 0, prg_addr[14:13] equal mmc_prg[1:0], and core_cpu_a14/core_cpu_a13 equal cpu_hi[1]/cpu_hi[0] (cpu_hi[2:0] carries CPU A15..A13).
- R2: With prg_mode equal to 1, 2 or 3, core_cpu_a13 and core_cpu_a14 are both 0.
- R3: With prg_mode equal to 1 or 2 (16 KiB fixed), prg_addr[13] equals CPU A13 and prg_addr[14] equals mmc_prg[1].
- R4: With prg_mode = 3 (32 KiB fixed), prg_addr[14:13] equal CPU A14..A13.
- R5: prg_addr[21:18] always equal prg_outer[3:0], and prg_addr[16:15] always equal mmc_prg[3:2].
- R6: prg_addr[17] equals prg_a17_bit when prg_a17_sel = 1 and mmc_prg[4] when prg_a17_sel = 0.
- R7: chr_addr[19:18] always equal chr_outer[2:1]. chr_addr[17] equals chr_outer[0] when chr_a17_sel = 1 and mmc_chr[7] otherwise.
- R8: With chr_fixed = 1, chr_addr[16:13] equal chr_inner and chr_addr[12:10] equal PPU A12..A10 (ppu_hi[2:0], with ppu_hi[3] being PPU A13).
- R9: With chr_fixed = 0, chr_addr[16:10] equal mmc_chr[6:0].
- R10: When pad_sel = 1 and CPU A15 = 1, cpu_dout = {6'b0, pad_val}. In every other case cpu_dout equals rom_data.
- R11: prg_ce equals CPU A15, and chr_ce is high exactly when PPU A13 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_hi | input | 3 | CPU address A15..A13 |
| ppu_hi | input | 4 | PPU address A13..A10 |
| mmc_prg | input | 5 | Core PRG bank output A17..A13 |
| mmc_chr | input | 8 | Core CHR bank output A17..A10 |
| prg_outer | input | 4 | Outer PRG bank, A21..A18 |
| prg_a17_bit | input | 1 | Register value for PRG A17 |
| prg_a17_sel | input | 1 | 1: PRG A17 from register (128 KiB inner bank) |
| chr_outer | input | 3 | Outer CHR bank, A19..A17 |
| chr_a17_sel | input | 1 | 1: CHR A17 from chr_outer[0] |
| chr_inner | input | 4 | Fixed-mode CHR bank, A16..A13 |
| prg_mode | input | 2 | 0 banked, 1/2 16 KiB fixed, 3 32 KiB fixed |
| chr_fixed | input | 1 | 1: 8 KiB fixed CHR bank from chr_inner |
| pad_sel | input | 1 | 1: ROM-window reads return pad bits |
| pad_val | input | 2 | Configuration pad bits |
| rom_data | input | 8 | PRG-ROM read data |
| core_cpu_a13 | output | 1 | CPU A13 as seen by the core |
| core_cpu_a14 | output | 1 | CPU A14 as seen by the core |
| prg_addr | output | 9 | PRG-ROM address A21..A13 |
| chr_addr | output | 10 | CHR-ROM address A19..A10 |
| prg_ce | output | 1 | PRG-ROM chip enable |
| chr_ce | output | 1 | CHR-ROM chip enable |
| cpu_dout | output | 8 | Data returned to the CPU |

## Verification
The bench first sweeps every PRG mode against all eight CPU A15..A13 values. It keeps the core's A14/A13 outputs opposite to the CPU lines, so that a bit taken from the wrong source shows up. This separates the 16 KiB and 32 KiB fixed modes from banked mode and from each other. Both CHR modes run against all PPU A13..A10 values, with core and inner bank bits set to contrasting patterns. Random vectors then toggle every select bit, and the pad path is tried both inside and outside the ROM window.

// File: rtl/mc_addr_composer.sv
module mc_addr_composer (
  input  logic [2:0] cpu_hi,
  input  logic [3:0] ppu_hi,
  input  logic [4:0] mmc_prg,
  input  logic [7:0] mmc_chr,
  input  logic [3:0] prg_outer,
  input  logic       prg_a17_bit,
  input  logic       prg_a17_sel,
  input  logic [2:0] chr_outer,
  input  logic       chr_a17_sel,
  input  logic [3:0] chr_inner,
  input  logic [1:0] prg_mode,
  input  logic       chr_fixed,
  input  logic       pad_sel,
  input  logic [1:0] pad_val,
  input  logic [7:0] rom_data,
  output logic       core_cpu_a13,
  output logic       core_cpu_a14,
  output logic [8:0] prg_addr,
  output logic [9:0] chr_addr,
  output logic       prg_ce,
  output logic       chr_ce,
  output logic [7:0] cpu_dout
);
  logic fixed_prg, wide_prg, win;

  assign fixed_prg = prg_mode != 2'd0;
  assign wide_prg  = prg_mode == 2'd3;
  assign win       = cpu_hi[2];

  assign core_cpu_a13 = fixed_prg ? 1'b0 : cpu_hi[0];
  assign core_cpu_a14 = fixed_prg ? 1'b0 : cpu_hi[1];

  assign prg_addr[8:5] = prg_outer;
  assign prg_addr[4]   = prg_a17_sel ? prg_a17_bit : mmc_prg[4];
  assign prg_addr[3:2] = mmc_prg[3:2];
  assign prg_addr[1]   = wide_prg ? cpu_hi[1] : mmc_prg[1];
  assign prg_addr[0]   = fixed_prg ? cpu_hi[0] : mmc_prg[0];

  assign chr_addr[9:8] = chr_outer[2:1];
  assign chr_addr[7]   = chr_a17_sel ? chr_outer[0] : mmc_chr[7];
  assign chr_addr[6:0] = chr_fixed ? {chr_inner, ppu_hi[2:0]} : mmc_chr[6:0];

  assign prg_ce = win;
  assign chr_ce = ~ppu_hi[3];

  assign cpu_dout = (pad_sel && win) ? {6'b0, pad_val} : rom_data;
endmodule

// File: rtl/mc_addr_composer_chk.sv
module mc_addr_composer_chk (
  input logic [2:0] cpu_hi,
  input logic [3:0] ppu_hi,
  input logic [4:0] mmc_prg,
  input logic [7:0] mmc_chr,
  input logic [3:0] prg_outer,
  input logic [3:0] chr_inner,
  input logic [2:0] chr_outer,
  input logic [1:0] prg_mode,
  input logic       chr_fixed,
  input logic       pad_sel,
  input logic [1:0] pad_val,
  input logic [7:0] rom_data,
  input logic       core_cpu_a13,
  input logic       core_cpu_a14,
  input logic [8:0] prg_addr,
  input logic [9:0] chr_addr,
  input logic [7:0] cpu_dout
);
  always_comb begin
    if (prg_mode != 2'd0)
      p_core_low_r2: assert (!core_cpu_a13 && !core_cpu_a14);
    if (prg_mode == 2'd0)
      p_pass_through_r1: assert (prg_addr[1:0] == mmc_prg[1:0] && {core_cpu_a14, core_cpu_a13} == cpu_hi[1:0]);
    if (prg_mode == 2'd3)
      p_wide_lines_r4: assert (prg_addr[1:0] == cpu_hi[1:0]);
    p_outer_prg_r5: assert (prg_addr[8:5] == prg_outer && prg_addr[3:2] == mmc_prg[3:2]);
    p_outer_chr_r7: assert (chr_addr[9:8] == chr_outer[2:1]);
    if (chr_fixed)
      p_fixed_chr_r8: assert (chr_addr[6:0] == {chr_inner, ppu_hi[2:0]});
    if (!cpu_hi[2] || !pad_sel)
      p_rom_data_r10: assert (cpu_dout == rom_data);
    else
      p_pad_data_r10: assert (cpu_dout[1:0] == pad_val && cpu_dout[7:2] == 6'd0);
  end
endmodule

bind mc_addr_composer mc_addr_composer_chk chk (.*);

// File: tb/mc_addr_composer_test.sv
module mc_addr_composer_test;
  logic clk = 0;
  always #2 clk = ~clk;

  logic [2:0] cpu_hi;    logic [3:0] ppu_hi;
  logic [4:0] mmc_prg;   logic [7:0] mmc_chr;
  logic [3:0] prg_outer; logic prg_a17_bit, prg_a17_sel;
  logic [2:0] chr_outer; logic chr_a17_sel;
  logic [3:0] chr_inner; logic [1:0] prg_mode;
  logic chr_fixed, pad_sel; logic [1:0] pad_val; logic [7:0] rom_data;
  logic core_cpu_a13, core_cpu_a14, prg_ce, chr_ce;
  logic [8:0] prg_addr; logic [9:0] chr_addr; logic [7:0] cpu_dout;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  mc_addr_composer uut (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference: byte addresses, then shifted down to bank lines
  task automatic compare();
    int cpu_byte, prg_byte, bank16, chr_byte, a13, a14;
    cpu_byte = cpu_hi * 8192;
    a13 = (cpu_byte / 8192) % 2;
    a14 = (cpu_byte / 16384) % 2;
    if (prg_mode == 0) begin
      check("R1 core a13", core_cpu_a13, a13);
      check("R1 core a14", core_cpu_a14, a14);
    end else begin
      check("R2 core a13", core_cpu_a13, 0);
      check("R2 core a14", core_cpu_a14, 0);
    end
    bank16 = (prg_mode == 3) ? a14 : (mmc_prg / 2) % 2;
    prg_byte = prg_outer * 262144
             + (prg_a17_sel ? prg_a17_bit : (mmc_prg / 16)) * 131072
             + ((mmc_prg / 4) % 4) * 32768
             + bank16 * 16384
             + ((prg_mode == 0) ? (mmc_prg % 2) : a13) * 8192;
    check(prg_mode == 0 ? "R1 prg_addr" : (prg_mode == 3 ? "R4 prg_addr" : "R3 prg_addr"),
          prg_addr, prg_byte / 8192);
    check("R5 prg outer", prg_addr / 32, prg_outer);
    check("R6 prg a17", (prg_addr / 16) % 2, prg_a17_sel ? prg_a17_bit : mmc_prg / 16);
    chr_byte = (chr_outer / 2) * 262144
             + (chr_a17_sel ? chr_outer % 2 : mmc_chr / 128) * 131072
             + (chr_fixed ? chr_inner * 8192 + (ppu_hi % 8) * 1024 : (mmc_chr % 128) * 1024);
    check("R7 chr high", chr_addr / 128, chr_byte / 131072);
    check(chr_fixed ? "R8 chr low" : "R9 chr low", chr_addr % 128, (chr_byte / 1024) % 128);
    check("R11 prg_ce", prg_ce, cpu_hi / 4);
    check("R11 chr_ce", chr_ce, ppu_hi < 8);
    check("R10 cpu_dout", cpu_dout, (pad_sel && cpu_hi >= 4) ? pad_val : rom_data);
  endtask

  task automatic step();
    @(negedge clk); #1; compare();
  endtask

  task automatic scramble();
    {cpu_hi, ppu_hi, mmc_prg, mmc_chr, prg_outer, prg_a17_bit, prg_a17_sel} = 24'($urandom);
    {chr_outer, chr_a17_sel, chr_inner, prg_mode, chr_fixed, pad_sel, pad_val, rom_data} = 23'($urandom);
  endtask

  initial begin
    {cpu_hi, ppu_hi, mmc_prg, mmc_chr, prg_outer, prg_a17_bit, prg_a17_sel} = '0;
    {chr_outer, chr_a17_sel, chr_inner, prg_mode, chr_fixed, pad_sel, pad_val, rom_data} = '0;
    @(negedge clk); #1;
    check("R5 zero inputs prg", prg_addr, 0);
    check("R9 zero inputs chr", chr_addr, 0);
    check("R11 zero inputs chr_ce", chr_ce, 1);
    // PRG modes vs CPU lines, core A14/A13 opposite to CPU
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 8; c++) begin
        @(posedge clk);
        prg_mode = 2'(m); cpu_hi = 3'(c);
        mmc_prg = {3'b101, ~cpu_hi[1], ~cpu_hi[0]};
        prg_outer = 4'hA; prg_a17_sel = m[0]; prg_a17_bit = 1'b0;
        step();
      end
    // CHR modes vs PPU lines
    for (int f = 0; f < 2; f++)
      for (int p = 0; p < 16; p++) begin
        @(posedge clk);
        chr_fixed = f[0]; ppu_hi = 4'(p);
        mmc_chr = {1'b1, 3'b010, ~ppu_hi[2:0]}; chr_inner = 4'b1011;
        chr_outer = 3'b100; chr_a17_sel = p[0];
        step();
      end
    // pad path inside / outside the ROM window
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      pad_sel = k[0]; cpu_hi = k[1] ? 3'd5 : 3'd2; pad_val = 2'b10; rom_data = 8'h7D;
      step();
    end
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); scramble(); step();
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); n_chk++; n_fail++; $display("FAIL watchdog: actual timeout expected completion"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule